// File: doc/BRIEF.md
# FIFO Watermark DMA Request Generator

This block sits beside a 128-word data FIFO that buffers words between a card-side data path and a system DMA engine. It watches the FIFO fill level. It raises a read DMA request when enough received words are waiting to be drained. It raises a write DMA request when enough free space exists to accept a new block of words. Each direction has its own threshold. The threshold serves two purposes: it is the trigger level, and it is the total number of words one request covers in a back-to-back burst sequence.

After a request is raised, the block counts one word for each acknowledge strobe from the DMA side. It splits the sequence into bursts no longer than the programmed burst length and reports the size of the current burst. The request stays high until the whole sequence has been moved, or until the transfer it belongs to is withdrawn. Software programs the two thresholds through one 32-bit control word and the two burst lengths through a second word.

Top module: `wm_dma_req_gen`

## Requirements
- R1: After reset, the threshold word (`cfg_sel`=0) reads 0x00100010: the read threshold sits in bits 7:0 and the write threshold in bits 23:16, both equal to 16. Every other bit reads zero, whatever was written to it.
- R2: A threshold field written as 0 is stored as 1. A threshold field written above 128 is stored as 128. Values from 1 to 128 are stored unchanged.
- R3: The burst word (`cfg_sel`=1) holds the read burst length in bits 4:0 and the write burst length in bits 20:16. Both reset to 8. A length written as 0 is stored as 1. All other bits read zero.
- R4: With `xfer_active`=1 and `xfer_dir`=0 (read), `rd_req` rises on the clock edge after one at which `fifo_level` is at least the read threshold. It stays low while the level is below the threshold.
- R5: With `xfer_active`=1 and `xfer_dir`=1 (write), `wr_req` rises on the clock edge after one at which 128 − `fifo_level` is at least the write threshold. It stays low while the free space is below the threshold.
- R6: A raised request stays high, whatever the level does, until the number of `beat_ack` strobes equals the threshold captured when the request rose. It falls at the edge that takes the final strobe. Strobes seen while no request is high have no effect.
- R7: After a sequence completes, the request is low for exactly one cycle. It rises again at the next edge if the level condition still holds.
- R8: While a request is high, `burst_words` equals the smaller of the captured burst length and the words left in the current burst's share of the sequence. The last burst is therefore shortened. `burst_last` is high while the next strobe completes the current burst. Both outputs are 0 while no request is high.
- R9: A raised request falls at the next edge if `xfer_active` drops or `xfer_dir` changes. A request for the new direction may rise at that same edge.
- R10: Writing a new threshold or burst length while a request is high does not change the length or burst split of the sequence in progress.
- R11: `rd_req` and `wr_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 thresholds, 1 burst lengths |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration word |
| fifo_level | input | 8 | Words currently held in the FIFO (0 to 128) |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | Transfer direction: 0 read, 1 write |
| beat_ack | input | 1 | DMA moved one word this cycle |
| rd_req | output | 1 | Read DMA request |
| wr_req | output | 1 | Write DMA request |
| burst_words | output | 5 | Size of the current burst |
| burst_last | output | 1 | Next strobe completes the current burst |

## Verification
On every cycle, the in-line assertions check the following: the two requests are mutually exclusive, a request only rises after a sampled level that meets its threshold, a request is held until its word count is reached, the counter never passes the captured length, a burst size stays within 1 and the captured burst length, and written thresholds and lengths are clamped. Only the bench scenarios can show the rest. These are the exact trigger boundaries, the one-cycle gap before a request rises again, the shortened final burst of a 128-word sequence with 31-word bursts, the way idle strobes are ignored, and the way a threshold rewritten mid-sequence is not picked up by that sequence.

// File: rtl/wm_pkg.sv
package wm_pkg;
   typedef enum logic {
      WM_DIR_RD = 1'b0,
      WM_DIR_WR = 1'b1
   } wm_dir_e;

   typedef enum logic {
      WM_SEL_THR   = 1'b0,
      WM_SEL_BURST = 1'b1
   } wm_sel_e;

   localparam int unsigned WM_RD_LSB = 0;
   localparam int unsigned WM_WR_LSB = 16;
   localparam int unsigned WM_WORD_W = 32;
endpackage

// File: rtl/wm_cfg_regs.sv
module wm_cfg_regs #(
   parameter int unsigned DEPTH   = 128,
   parameter int unsigned LVL_W   = $clog2(DEPTH + 1),
   parameter int unsigned BL_W    = 5,
   parameter int unsigned RST_THR = 16,
   parameter int unsigned RST_BL  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic                          sel,
   input  logic [wm_pkg::WM_WORD_W-1:0]  wdata,
   output logic [wm_pkg::WM_WORD_W-1:0]  rdata,
   output logic [LVL_W-1:0]              thr_rd,
   output logic [LVL_W-1:0]              thr_wr,
   output logic [BL_W-1:0]               bl_rd,
   output logic [BL_W-1:0]               bl_wr
);
   import wm_pkg::*;

   localparam logic [LVL_W-1:0] THR_MAX = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] THR_RST = LVL_W'(RST_THR);
   localparam logic [BL_W-1:0]  BL_RST  = BL_W'(RST_BL);

   if (RST_THR < 1 || RST_THR > DEPTH) begin : g_bad_rst_thr
      $error("RST_THR must lie in 1..DEPTH");
   end
   if (RST_BL < 1 || RST_BL >= (1 << BL_W)) begin : g_bad_rst_bl
      $error("RST_BL must fit BL_W and be non-zero");
   end
   if (WM_WR_LSB + LVL_W > WM_WORD_W) begin : g_bad_field
      $error("threshold field does not fit the control word");
   end

   function automatic logic [LVL_W-1:0] clamp_thr(input logic [LVL_W-1:0] v);
      if (v == '0)          return LVL_W'(1);
      else if (v > THR_MAX) return THR_MAX;
      else                  return v;
   endfunction

   function automatic logic [BL_W-1:0] clamp_bl(input logic [BL_W-1:0] v);
      return (v == '0) ? BL_W'(1) : v;
   endfunction

   logic [LVL_W-1:0] f_thr_rd, f_thr_wr;
   logic [BL_W-1:0]  f_bl_rd, f_bl_wr;
   logic             unused_wdata_bits;

   assign f_thr_rd = wdata[WM_RD_LSB +: LVL_W];
   assign f_thr_wr = wdata[WM_WR_LSB +: LVL_W];
   assign f_bl_rd  = wdata[WM_RD_LSB +: BL_W];
   assign f_bl_wr  = wdata[WM_WR_LSB +: BL_W];
   assign unused_wdata_bits = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_rd <= THR_RST;
         thr_wr <= THR_RST;
         bl_rd  <= BL_RST;
         bl_wr  <= BL_RST;
      end else if (we) begin
         if (sel == WM_SEL_THR) begin
            thr_rd <= clamp_thr(f_thr_rd);
            thr_wr <= clamp_thr(f_thr_wr);
         end else begin
            bl_rd <= clamp_bl(f_bl_rd);
            bl_wr <= clamp_bl(f_bl_wr);
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (sel == WM_SEL_THR) begin
         rdata[WM_RD_LSB +: LVL_W] = thr_rd;
         rdata[WM_WR_LSB +: LVL_W] = thr_wr;
      end else begin
         rdata[WM_RD_LSB +: BL_W] = bl_rd;
         rdata[WM_WR_LSB +: BL_W] = bl_wr;
      end
   end

   assert_thr_zero_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == WM_SEL_THR && f_thr_rd == '0) |=> (thr_rd == LVL_W'(1)));

   assert_thr_high_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == WM_SEL_THR && f_thr_wr > THR_MAX) |=> (thr_wr == THR_MAX));

   assert_bl_zero_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == WM_SEL_BURST && f_bl_wr == '0) |=> (bl_wr == BL_W'(1)));
endmodule

// File: rtl/wm_channel.sv
module wm_channel #(
   parameter int unsigned DEPTH    = 128,
   parameter int unsigned LVL_W    = $clog2(DEPTH + 1),
   parameter int unsigned BL_W     = 5,
   parameter bit          IS_WRITE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [LVL_W-1:0]  level,
   input  logic [LVL_W-1:0]  thr,
   input  logic [BL_W-1:0]   bl,
   input  logic              beat,
   output logic              req,
   output logic [BL_W-1:0]   burst_sz,
   output logic              burst_end
);
   if (BL_W > LVL_W) begin : g_bad_bl_w
      $error("BL_W must not exceed LVL_W");
   end

   logic [LVL_W-1:0] avail;
   logic             busy;
   logic [LVL_W-1:0] seq_len, seq_cnt, base;
   logic [BL_W-1:0]  bl_cap;
   logic [LVL_W-1:0] remain, pos, cnt_nxt;
   logic             fire, seq_done;

   if (IS_WRITE) begin : g_free
      assign avail = LVL_W'(DEPTH) - level;
   end else begin : g_fill
      assign avail = level;
   end

   assign remain    = seq_len - base;
   assign pos       = seq_cnt - base;
   assign cnt_nxt   = seq_cnt + LVL_W'(1);
   assign burst_sz  = !busy ? '0 :
                      ((LVL_W'(bl_cap) < remain) ? bl_cap : remain[BL_W-1:0]);
   assign burst_end = busy && ((pos + LVL_W'(1)) == LVL_W'(burst_sz));
   assign fire      = enable && (avail >= thr);
   assign seq_done  = beat && (cnt_nxt == seq_len);
   assign req       = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         seq_len <= '0;
         seq_cnt <= '0;
         base    <= '0;
         bl_cap  <= '0;
      end else if (busy) begin
         if (!enable) begin
            busy <= 1'b0;
         end else if (beat) begin
            seq_cnt <= cnt_nxt;
            if (burst_end) base <= cnt_nxt;
            if (seq_done)  busy <= 1'b0;
         end
      end else if (fire) begin
         busy    <= 1'b1;
         seq_len <= thr;
         bl_cap  <= bl;
         seq_cnt <= '0;
         base    <= '0;
      end
   end

   assert_rise_needs_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(enable && (avail >= thr)));

   assert_hold_until_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && enable && !seq_done) |=> req);

   assert_drop_on_last_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && enable && seq_done) |=> !req);

   assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (seq_cnt < seq_len));

   assert_burst_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (burst_sz != '0 && burst_sz <= bl_cap));

   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !enable) |=> !req);

   assert_len_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && $past(req)) |-> $stable(seq_len));
endmodule

// File: rtl/wm_dma_req_gen.sv
module wm_dma_req_gen #(
   parameter int unsigned DEPTH   = 128,
   parameter int unsigned LVL_W   = $clog2(DEPTH + 1),
   parameter int unsigned BL_W    = 5,
   parameter int unsigned RST_THR = 16,
   parameter int unsigned RST_BL  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic [LVL_W-1:0]  fifo_level,
   input  logic              xfer_active,
   input  logic              xfer_dir,
   input  logic              beat_ack,
   output logic              rd_req,
   output logic              wr_req,
   output logic [BL_W-1:0]   burst_words,
   output logic              burst_last
);
   import wm_pkg::*;

   localparam int unsigned NCH = 2;

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [LVL_W-1:0] thr_v [NCH];
   logic [BL_W-1:0]  bl_v  [NCH];
   logic             req_v [NCH];
   logic [BL_W-1:0]  bw_v  [NCH];
   logic             be_v  [NCH];

   wm_cfg_regs #(
      .DEPTH(DEPTH), .LVL_W(LVL_W), .BL_W(BL_W),
      .RST_THR(RST_THR), .RST_BL(RST_BL)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(cfg_wdata), .rdata(cfg_rdata),
      .thr_rd(thr_v[0]), .thr_wr(thr_v[1]),
      .bl_rd(bl_v[0]), .bl_wr(bl_v[1])
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic ch_en;
      assign ch_en = xfer_active && (xfer_dir == ((g == 1) ? WM_DIR_WR : WM_DIR_RD));

      wm_channel #(
         .DEPTH(DEPTH), .LVL_W(LVL_W), .BL_W(BL_W), .IS_WRITE(g == 1)
      ) u_ch (
         .clk(clk), .rst_n(rst_n), .enable(ch_en), .level(fifo_level),
         .thr(thr_v[g]), .bl(bl_v[g]), .beat(beat_ack),
         .req(req_v[g]), .burst_sz(bw_v[g]), .burst_end(be_v[g])
      );
   end

   assign rd_req      = req_v[0];
   assign wr_req      = req_v[1];
   assign burst_words = bw_v[0] | bw_v[1];
   assign burst_last  = be_v[0] | be_v[1];

   assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   assert_idle_burst_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_req && !wr_req) |-> (burst_words == '0 && !burst_last));
endmodule

// File: tb/sim_wm_dma_req_gen.sv
module sim_wm_dma_req_gen;
   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic [7:0]  fifo_level = '0;
   logic        xfer_active = 1'b0, xfer_dir = 1'b0, beat_ack = 1'b0;
   logic        rd_req, wr_req, burst_last;
   logic [4:0]  burst_words;

   int checks = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   wm_dma_req_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fifo_level(fifo_level),
      .xfer_active(xfer_active), .xfer_dir(xfer_dir), .beat_ack(beat_ack),
      .rd_req(rd_req), .wr_req(wr_req), .burst_words(burst_words),
      .burst_last(burst_last)
   );

   // behavioural reference model
   int  m_thr[2], m_bl[2], m_len[2], m_cnt[2], m_base[2], m_blk[2];
   bit  m_busy[2];

   function automatic int clamp_t(int v);
      if (v == 0) return 1;
      if (v > DEPTH) return DEPTH;
      return v;
   endfunction

   function automatic int m_words(int c);
      int left;
      if (!m_busy[c]) return 0;
      left = m_len[c] - m_base[c];
      return (m_blk[c] < left) ? m_blk[c] : left;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            m_thr[c] = 16; m_bl[c] = 8; m_busy[c] = 0;
            m_len[c] = 0; m_cnt[c] = 0; m_base[c] = 0; m_blk[c] = 0;
         end
      end else begin
         for (int c = 0; c < 2; c++) begin
            bit en;
            int avail;
            en = xfer_active && (int'(xfer_dir) == c);
            avail = (c == 1) ? DEPTH - int'(fifo_level) : int'(fifo_level);
            if (m_busy[c]) begin
               if (!en) m_busy[c] = 0;
               else if (beat_ack) begin
                  int w;
                  w = m_words(c);
                  m_cnt[c]++;
                  if (m_cnt[c] - m_base[c] == w) m_base[c] = m_cnt[c];
                  if (m_cnt[c] == m_len[c]) m_busy[c] = 0;
               end
            end else if (en && avail >= m_thr[c]) begin
               m_busy[c] = 1; m_len[c] = m_thr[c]; m_blk[c] = m_bl[c];
               m_cnt[c] = 0; m_base[c] = 0;
            end
         end
         if (cfg_we) begin
            if (!cfg_sel) begin
               m_thr[0] = clamp_t(int'(cfg_wdata[7:0]));
               m_thr[1] = clamp_t(int'(cfg_wdata[23:16]));
            end else begin
               m_bl[0] = (cfg_wdata[4:0] == 0) ? 1 : int'(cfg_wdata[4:0]);
               m_bl[1] = (cfg_wdata[20:16] == 0) ? 1 : int'(cfg_wdata[20:16]);
            end
         end
      end
   end

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int w, e_last;
         logic [31:0] e_rd;
         w = m_words(0) | m_words(1);
         e_last = 0;
         for (int c = 0; c < 2; c++)
            if (m_busy[c] && (m_cnt[c] - m_base[c] + 1 == m_words(c))) e_last = 1;
         e_rd = cfg_sel ? ((32'(m_bl[1]) << 16) | 32'(m_bl[0]))
                        : ((32'(m_thr[1]) << 16) | 32'(m_thr[0]));
         chk(cfg_rdata == e_rd, "R1 cfg_rdata", cfg_rdata, e_rd);
         chk(rd_req == m_busy[0], "R4 rd_req", rd_req, m_busy[0]);
         chk(wr_req == m_busy[1], "R5 wr_req", wr_req, m_busy[1]);
         chk(int'(burst_words) == w, "R8 burst_words", burst_words, w);
         chk(int'(burst_last) == e_last, "R8 burst_last", burst_last, e_last);
         chk(!(rd_req && wr_req), "R11 exclusive", {rd_req, wr_req}, 0);
      end
   end

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wcfg(bit sel, logic [31:0] d);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk(cfg_rdata == 32'h0010_0010, "R1 reset thresholds", cfg_rdata, 32'h0010_0010);
      chk(!rd_req && !wr_req, "R4 reset requests", {rd_req, wr_req}, 0);
      cfg_sel = 1'b1;
      tick();
      chk(cfg_rdata == 32'h0008_0008, "R3 reset burst", cfg_rdata, 32'h0008_0008);

      wcfg(0, 32'h0000_0000);
      chk(cfg_rdata == 32'h0001_0001, "R2 zero clamp", cfg_rdata, 32'h0001_0001);
      wcfg(0, 32'h00FF_0081);
      chk(cfg_rdata == 32'h0080_0080, "R2 high clamp", cfg_rdata, 32'h0080_0080);
      wcfg(0, 32'hFF05_FF04);
      chk(cfg_rdata == 32'h0005_0004, "R1 reserved zero", cfg_rdata, 32'h0005_0004);
      wcfg(1, 32'hFFE3_FFE3);
      chk(cfg_rdata == 32'h0003_0003, "R3 burst fields", cfg_rdata, 32'h0003_0003);
      wcfg(1, 32'h0000_0000);
      chk(cfg_rdata == 32'h0001_0001, "R3 burst zero clamp", cfg_rdata, 32'h0001_0001);
      wcfg(1, 32'h0002_0003);
      wcfg(0, 32'h0004_0008);

      // read trigger boundary
      xfer_active = 1'b1; xfer_dir = 1'b0; fifo_level = 8'd7;
      tick(); tick();
      chk(!rd_req, "R4 below threshold", rd_req, 0);
      fifo_level = 8'd8;
      tick();
      chk(rd_req, "R4 at threshold", rd_req, 1);
      fifo_level = 8'd0;
      tick();
      chk(rd_req, "R6 held on empty level", rd_req, 1);
      wcfg(0, 32'h0004_0002);   // R10: new threshold mid-sequence
      for (int k = 0; k < 8; k++) begin
         int b, w;
         b = (k / 3) * 3;
         w = (8 - b < 3) ? 8 - b : 3;
         chk(rd_req, "R10 sequence length kept", rd_req, 1);
         chk(int'(burst_words) == w, "R8 burst split", burst_words, w);
         chk(burst_last == (k - b + 1 == w), "R8 burst end", burst_last, (k - b + 1 == w));
         beat_ack = 1'b1;
         tick();
      end
      beat_ack = 1'b0;
      chk(!rd_req, "R6 drop after final word", rd_req, 0);
      beat_ack = 1'b1;
      repeat (3) tick();
      chk(!rd_req, "R6 idle strobes ignored", rd_req, 0);
      beat_ack = 1'b0;

      // re-evaluation gap
      fifo_level = 8'd2;
      tick();
      chk(rd_req, "R4 new threshold", rd_req, 1);
      beat_ack = 1'b1;
      tick(); tick();
      beat_ack = 1'b0;
      chk(!rd_req, "R7 one-cycle gap", rd_req, 0);
      tick();
      chk(rd_req, "R7 re-raised", rd_req, 1);

      // abort paths
      xfer_active = 1'b0;
      tick();
      chk(!rd_req, "R9 abort on inactive", rd_req, 0);
      xfer_active = 1'b1;
      tick();
      xfer_dir = 1'b1;
      tick();
      chk(!rd_req, "R9 abort on direction", rd_req, 0);
      chk(wr_req, "R5 write starts", wr_req, 1);
      beat_ack = 1'b1;
      repeat (4) tick();
      beat_ack = 1'b0;
      chk(!wr_req, "R6 write sequence done", wr_req, 0);

      // write trigger boundary
      xfer_active = 1'b0; fifo_level = 8'd125;
      tick();
      xfer_active = 1'b1;
      tick(); tick();
      chk(!wr_req, "R5 free below threshold", wr_req, 0);
      fifo_level = 8'd124;
      tick();
      chk(wr_req, "R5 free at threshold", wr_req, 1);
      xfer_active = 1'b0;
      tick();

      // full 128-word read sequence, 31-word bursts
      wcfg(0, 32'h00FF_00FF);
      chk(cfg_rdata == 32'h0080_0080, "R2 max threshold", cfg_rdata, 32'h0080_0080);
      wcfg(1, 32'h001F_001F);
      xfer_dir = 1'b0; fifo_level = 8'd128; xfer_active = 1'b1;
      tick();
      chk(rd_req, "R4 full FIFO", rd_req, 1);
      beat_ack = 1'b1;
      for (int k = 0; k < 128; k++) begin
         int w;
         w = (k >= 124) ? 4 : 31;
         chk(int'(burst_words) == w, "R8 long sequence burst", burst_words, w);
         tick();
      end
      beat_ack = 1'b0;
      chk(!rd_req, "R6 128-word sequence done", rd_req, 0);
      xfer_active = 1'b0;
      tick();

      // write threshold of one
      wcfg(0, 32'h0001_0080);
      xfer_dir = 1'b1; fifo_level = 8'd127; xfer_active = 1'b1;
      tick();
      chk(wr_req, "R5 single free word", wr_req, 1);
      fifo_level = 8'd128; beat_ack = 1'b1;
      tick();
      beat_ack = 1'b0;
      chk(!wr_req, "R6 single word done", wr_req, 0);
      tick();
      chk(!wr_req, "R5 FIFO full no request", wr_req, 0);
      xfer_active = 1'b0;
      tick();

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule